// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Protocol Engine

This block is the bus-facing front end of a serial nonvolatile memory. It oversamples the SCL and SDA lines on the system clock, recognises start and stop conditions, shifts bytes in and out, and decides which bytes to acknowledge. SDA is driven only through an active-low open-drain enable. A surrounding bus resistor and wired-AND logic produce the line level that comes back in on `sda_i`.

The first byte after a start carries a four-bit device type code, three bits that must match the pin-strapped select inputs, and a direction bit. After a write-direction header, two address bytes follow. The block then presents the full address with a load strobe. Any further bytes go out one per write strobe, and a stop commits them. A stop straight after the address bytes only reloads the address. A repeated start at that point turns the transfer into a random read. In a read, the block fetches each byte from the memory side with a request pulse, sends it MSB first, and continues for as long as the master acknowledges.

While the memory side reports a self-timed write as busy, no header is acknowledged, so a master can poll for completion. The memory array, its address counter and the write timing live outside this block.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset SDA is released (`sda_oe_n` = 1) and none of the four memory-side strobes is asserted.
- R2: A header byte whose bits 7..4 are 1010 and whose bits 3..1 equal `sel_i` (bit 3 against `sel_i[2]`) is acknowledged by pulling SDA low for the ninth clock; bit 0 = 1 selects read, 0 selects write.
- R3: A header with a wrong type code or wrong select bits gets no acknowledge, and the block ignores all bus traffic until the next start: no acknowledge, no drive, no strobe.
- R4: While `busy_i` is high, no header is acknowledged, whether read or write; once `busy_i` is low, the same header is acknowledged again.
- R5: After a write header, two address bytes are each acknowledged; the low four bits of the first give address bits 11..8, the second gives bits 7..0, and `addr_load` pulses once with that address on `addr_o`.
- R6: Every data byte after the address bytes is acknowledged and produces one `wr_stb` pulse with the byte on `wr_data_o`.
- R7: A stop pulses `commit` once only if at least one data byte was written since the last start; a stop right after the two address bytes gives no `commit` and no `wr_stb`.
- R8: In a read, each byte is taken from `rd_data_i` with one `rd_req` pulse and sent MSB first; a master acknowledge on the ninth clock makes the block send the next byte.
- R9: A missing master acknowledge ends the read: the block drives nothing and issues no `rd_req` until the next start.
- R10: A repeated start after the address bytes, followed by a read header, is acknowledged, and the first byte sent is the one the memory side supplies for the just-loaded address.
- R11: A start in the middle of a byte aborts the transfer, resynchronises the bit counter so that the next header is decoded correctly, and discards pending write data (no `commit` at the later stop).
- R12: The SDA enable changes only while the synchronised SCL is low, and at most one of `addr_load`, `wr_stb`, `rd_req`, `commit` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired result) |
| sel_i | input | 3 | Pin-strapped select value compared with header bits 3..1 |
| busy_i | input | 1 | Memory side is in a self-timed write |
| rd_data_i | input | 8 | Byte at the memory side's current address |
| sda_oe_n | output | 1 | Active-low SDA pull-down enable |
| addr_load | output | 1 | One-cycle strobe: `addr_o` holds a new address |
| addr_o | output | 12 | Address assembled from the two address bytes |
| wr_stb | output | 1 | One-cycle strobe: `wr_data_o` holds a received data byte |
| wr_data_o | output | 8 | Last received data byte |
| rd_req | output | 1 | One-cycle strobe: `rd_data_i` was captured, advance the address |
| commit | output | 1 | One-cycle strobe on stop: start the nonvolatile write |

## Verification
Every decision takes effect three system cycles after the SCL pin edge that causes it: two synchroniser flops, then one state register. An acknowledge or data bit therefore appears on SDA about three cycles into the SCL low phase. The bench holds each SCL phase for 16 cycles and reads SDA eight cycles into the high phase, so a result is always sampled well after it is due and well before the next edge. The strobes are counted and logged at the falling clock edge, and each count is compared once the bus phase that should produce it has ended. This way a pulse that comes late or early within that phase still lands in the same comparison.

// File: rtl/twi_pkg.sv
package twi_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_DEV,
      PH_AHI,
      PH_ALO,
      PH_WDAT,
      PH_RDAT
   } phase_t;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
   parameter int W       = 2,
   parameter int STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("twi_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{RST_VAL}};
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/twi_line_events.sv
module twi_line_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;
   assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
   import twi_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 12,
   parameter int SEL_W       = 3,
   parameter int SYNC_STAGES = 2,
   parameter logic [DATA_W-SEL_W-2:0] TYPE_CODE = 4'b1010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [SEL_W-1:0]  sel_i,
   input  logic              busy_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              sda_oe_n,
   output logic              addr_load,
   output logic [ADDR_W-1:0] addr_o,
   output logic              wr_stb,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              rd_req,
   output logic              commit
);
   localparam int CNT_W  = $clog2(DATA_W + 2);
   localparam int HI_W   = ADDR_W - DATA_W;
   localparam int TYPE_W = DATA_W - 1 - SEL_W;
   localparam logic [CNT_W-1:0] ACK_IDX = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] NINTH   = CNT_W'(DATA_W + 1);

   generate
      if (HI_W < 1 || HI_W > DATA_W) begin : g_bad_addr
         $error("twi_mem_slave: ADDR_W must lie in DATA_W+1 .. 2*DATA_W");
      end
      if (TYPE_W < 1) begin : g_bad_type
         $error("twi_mem_slave: no room left for a type code");
      end
   endgenerate

   logic scl_s, sda_s;
   logic scl_rise, scl_fall, start_ev, stop_ev;

   twi_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_i, sda_i}),
      .q     ({scl_s, sda_s})
   );

   twi_line_events u_evt (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev)
   );

   phase_t            ph;
   logic [DATA_W-1:0] sh;
   logic [CNT_W-1:0]  cnt;
   logic [HI_W-1:0]   a_hi;
   logic              drv_low, mack, rnw, dirty;
   logic [TYPE_W-1:0] type_field;
   logic              addr_hit, dev_phase;

   assign type_field = sh[DATA_W-1 -: TYPE_W];
   assign addr_hit   = (type_field == TYPE_CODE) && (sh[SEL_W:1] == sel_i) && !busy_i;
   assign dev_phase  = (ph == PH_DEV);
   assign sda_oe_n   = ~drv_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph        <= PH_IDLE;
         sh        <= '0;
         cnt       <= '0;
         a_hi      <= '0;
         drv_low   <= 1'b0;
         mack      <= 1'b0;
         rnw       <= 1'b0;
         dirty     <= 1'b0;
         addr_o    <= '0;
         wr_data_o <= '0;
         addr_load <= 1'b0;
         wr_stb    <= 1'b0;
         rd_req    <= 1'b0;
         commit    <= 1'b0;
      end else begin
         addr_load <= 1'b0;
         wr_stb    <= 1'b0;
         rd_req    <= 1'b0;
         commit    <= 1'b0;
         if (start_ev) begin
            ph      <= PH_DEV;
            cnt     <= '0;
            drv_low <= 1'b0;
            dirty   <= 1'b0;
         end else if (stop_ev) begin
            ph      <= PH_IDLE;
            cnt     <= '0;
            drv_low <= 1'b0;
            dirty   <= 1'b0;
            commit  <= dirty;
         end else if (ph != PH_IDLE) begin
            if (scl_rise) begin
               if (cnt < ACK_IDX) begin
                  if (ph != PH_RDAT) sh <= {sh[DATA_W-2:0], sda_s};
                  cnt <= cnt + 1'b1;
               end else if (cnt == ACK_IDX) begin
                  mack <= ~sda_s;
                  cnt  <= NINTH;
               end
            end else if (scl_fall) begin
               if (cnt == ACK_IDX) begin
                  unique case (ph)
                     PH_DEV: begin
                        if (addr_hit) begin
                           drv_low <= 1'b1;
                           rnw     <= sh[0];
                        end else begin
                           ph <= PH_IDLE;
                        end
                     end
                     PH_AHI: begin
                        drv_low <= 1'b1;
                        a_hi    <= sh[HI_W-1:0];
                     end
                     PH_ALO: begin
                        drv_low   <= 1'b1;
                        addr_o    <= {a_hi, sh};
                        addr_load <= 1'b1;
                     end
                     PH_WDAT: begin
                        drv_low   <= 1'b1;
                        wr_data_o <= sh;
                        wr_stb    <= 1'b1;
                        dirty     <= 1'b1;
                     end
                     default: drv_low <= 1'b0;
                  endcase
               end else if (cnt == NINTH) begin
                  cnt     <= '0;
                  drv_low <= 1'b0;
                  unique case (ph)
                     PH_DEV: begin
                        if (rnw) begin
                           ph      <= PH_RDAT;
                           sh      <= rd_data_i;
                           drv_low <= ~rd_data_i[DATA_W-1];
                           rd_req  <= 1'b1;
                        end else begin
                           ph <= PH_AHI;
                        end
                     end
                     PH_AHI: ph <= PH_ALO;
                     PH_ALO: ph <= PH_WDAT;
                     PH_RDAT: begin
                        if (mack) begin
                           sh      <= rd_data_i;
                           drv_low <= ~rd_data_i[DATA_W-1];
                           rd_req  <= 1'b1;
                        end else begin
                           ph <= PH_IDLE;
                        end
                     end
                     default: ph <= ph;
                  endcase
               end else if (ph == PH_RDAT && cnt != '0) begin
                  sh      <= {sh[DATA_W-2:0], 1'b0};
                  drv_low <= ~sh[DATA_W-2];
               end
            end
         end
      end
   end
endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk #(
   parameter int TYPE_W = 4,
   parameter logic [TYPE_W-1:0] TYPE_CODE = 4'b1010
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_s,
   input logic              sda_oe_n,
   input logic              busy_i,
   input logic              dev_phase,
   input logic [TYPE_W-1:0] type_field,
   input logic              start_ev,
   input logic              addr_load,
   input logic              wr_stb,
   input logic              rd_req,
   input logic              commit
);
   logic wr_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 wr_seen <= 1'b0;
      else if (start_ev || commit) wr_seen <= 1'b0;
      else if (wr_stb)            wr_seen <= 1'b1;
   end

   AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && $past(scl_s)) |-> $stable(sda_oe_n)); // R12

   AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({addr_load, wr_stb, rd_req, commit})); // R12

   AST_HDR_TYPE_OK: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_phase && $fell(sda_oe_n)) |-> ($past(type_field) == TYPE_CODE)); // R2

   AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_phase && $fell(sda_oe_n)) |-> !$past(busy_i)); // R4

   AST_LOAD_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
      addr_load |-> !sda_oe_n); // R5

   AST_COMMIT_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> wr_seen); // R7
endmodule

bind twi_mem_slave twi_mem_slave_chk #(
   .TYPE_W    (TYPE_W),
   .TYPE_CODE (TYPE_CODE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .scl_s      (scl_s),
   .sda_oe_n   (sda_oe_n),
   .busy_i     (busy_i),
   .dev_phase  (dev_phase),
   .type_field (type_field),
   .start_ev   (start_ev),
   .addr_load  (addr_load),
   .wr_stb     (wr_stb),
   .rd_req     (rd_req),
   .commit     (commit)
);

// File: tb/sim_twi_mem_slave.sv
`timescale 1ns/1ps
module sim_twi_mem_slave;
   localparam int H = 16;
   localparam logic [2:0] SEL = 3'b101;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic busy = 1'b0;
   logic [7:0]  rd_data;
   logic        sda_oe_n, addr_load, wr_stb, rd_req, commit;
   logic [11:0] addr_o;
   logic [7:0]  wr_data_o;
   wire         sda_bus = m_sda & sda_oe_n;

   always #5 clk = ~clk;

   twi_mem_slave u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (m_scl),
      .sda_i     (sda_bus),
      .sel_i     (SEL),
      .busy_i    (busy),
      .rd_data_i (rd_data),
      .sda_oe_n  (sda_oe_n),
      .addr_load (addr_load),
      .addr_o    (addr_o),
      .wr_stb    (wr_stb),
      .wr_data_o (wr_data_o),
      .rd_req    (rd_req),
      .commit    (commit)
   );

   function automatic logic [7:0] mem_val(input logic [11:0] a);
      return a[7:0] ^ {4'h0, a[11:8]} ^ 8'hC3;
   endfunction

   // memory-side model and strobe monitors
   logic [11:0] mcnt = '0;
   int n_load = 0, n_wr = 0, n_rd = 0, n_commit = 0, n_drive = 0;
   int n_multi = 0, n_hi_change = 0;
   logic [11:0] last_addr = '0;
   logic [7:0]  wr_log [0:7];
   logic prev_oe = 1'b1, prev_scl = 1'b1;

   assign rd_data = mem_val(mcnt);

   always @(negedge clk) begin
      if (rst_n) begin
         if (addr_load) begin
            n_load++;
            last_addr = addr_o;
            mcnt = addr_o;
         end
         if (wr_stb) begin
            wr_log[n_wr % 8] = wr_data_o;
            n_wr++;
         end
         if (rd_req) begin
            n_rd++;
            mcnt = mcnt + 12'd1;
         end
         if (commit) n_commit++;
         if (!sda_oe_n) n_drive++;
         if ((int'(addr_load) + int'(wr_stb) + int'(rd_req) + int'(commit)) > 1) n_multi++;
         if (sda_oe_n != prev_oe && m_scl && prev_scl) n_hi_change++;
      end
      prev_oe  = sda_oe_n;
      prev_scl = m_scl;
   end

   int checks = 0, errors = 0;
   bit done = 1'b0;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic pause(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1;
      pause(H/2);
      m_scl = 1'b1;
      pause(H/2);
      m_sda = 1'b0;
      pause(H/2);
      m_scl = 1'b0;
   endtask

   task automatic bus_stop();
      m_sda = 1'b0;
      pause(H/2);
      m_scl = 1'b1;
      pause(H/2);
      m_sda = 1'b1;
      pause(H);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 0; i < n; i++) begin
         pause(H/2);
         m_sda = b[7-i];
         pause(H/2);
         m_scl = 1'b1;
         pause(H);
         m_scl = 1'b0;
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      send_bits(b, 8);
      pause(H/2);
      m_sda = 1'b1;
      pause(H/2);
      m_scl = 1'b1;
      pause(H/2);
      ack = ~sda_bus;
      pause(H/2);
      m_scl = 1'b0;
   endtask

   task automatic recv_byte(output logic [7:0] d, input logic give_ack);
      m_sda = 1'b1;
      for (int i = 0; i < 8; i++) begin
         pause(H);
         m_scl = 1'b1;
         pause(H/2);
         d[7-i] = sda_bus;
         pause(H/2);
         m_scl = 1'b0;
      end
      pause(H/2);
      m_sda = give_ack ? 1'b0 : 1'b1;
      pause(H/2);
      m_scl = 1'b1;
      pause(H);
      m_scl = 1'b0;
      pause(2);
      m_sda = 1'b1;
   endtask

   localparam logic [7:0] HDR_W = {4'b1010, SEL, 1'b0};
   localparam logic [7:0] HDR_R = {4'b1010, SEL, 1'b1};

   task automatic t_reset();
      chk("R1 sda released", int'(sda_oe_n), 1);
      chk("R1 no strobes", n_load + n_wr + n_rd + n_commit, 0);
   endtask

   task automatic t_page_write();
      logic ack;
      bus_start();
      send_byte(HDR_W, ack);     chk("R2 write header ack", int'(ack), 1);
      send_byte(8'h0A, ack);     chk("R5 addr hi ack", int'(ack), 1);
      send_byte(8'h5C, ack);     chk("R5 addr lo ack", int'(ack), 1);
      chk("R5 load count", n_load, 1);
      chk("R5 loaded address", int'(last_addr), 'hA5C);
      send_byte(8'h3C, ack);     chk("R6 data0 ack", int'(ack), 1);
      send_byte(8'h99, ack);     chk("R6 data1 ack", int'(ack), 1);
      send_byte(8'h00, ack);     chk("R6 data2 ack", int'(ack), 1);
      chk("R6 write strobes", n_wr, 3);
      chk("R6 byte0", int'(wr_log[0]), 'h3C);
      chk("R6 byte1", int'(wr_log[1]), 'h99);
      chk("R6 byte2", int'(wr_log[2]), 'h00);
      bus_stop();
      pause(4);
      chk("R7 commit after data", n_commit, 1);
   endtask

   task automatic t_mismatch();
      logic ack;
      int drv0, ld0;
      drv0 = n_drive;
      ld0  = n_load;
      bus_start();
      send_byte(8'b1011_1010, ack); chk("R3 bad type no ack", int'(ack), 0);
      send_byte(8'h00, ack);        chk("R3 ignored byte no ack", int'(ack), 0);
      send_byte(8'h10, ack);        chk("R3 ignored byte2 no ack", int'(ack), 0);
      send_byte(8'h55, ack);        chk("R3 ignored byte3 no ack", int'(ack), 0);
      bus_stop();
      bus_start();
      send_byte({4'b1010, SEL ^ 3'b001, 1'b1}, ack); chk("R3 bad select no ack", int'(ack), 0);
      bus_stop();
      chk("R3 no drive", n_drive - drv0, 0);
      chk("R3 no load", n_load - ld0, 0);
   endtask

   task automatic t_busy();
      logic ack;
      busy = 1'b1;
      bus_start();
      send_byte(HDR_W, ack);  chk("R4 busy write header", int'(ack), 0);
      bus_stop();
      bus_start();
      send_byte(HDR_R, ack);  chk("R4 busy read header", int'(ack), 0);
      bus_stop();
      busy = 1'b0;
      bus_start();
      send_byte(HDR_W, ack);  chk("R4 ack after busy clears", int'(ack), 1);
      bus_stop();
   endtask

   task automatic t_set_addr();
      logic ack;
      int c0, w0, l0;
      c0 = n_commit; w0 = n_wr; l0 = n_load;
      bus_start();
      send_byte(HDR_W, ack);
      send_byte(8'h00, ack);
      send_byte(8'h40, ack);
      bus_stop();
      pause(4);
      chk("R7 set-address load", n_load - l0, 1);
      chk("R7 set-address value", int'(last_addr), 'h040);
      chk("R7 set-address no commit", n_commit - c0, 0);
      chk("R7 set-address no write", n_wr - w0, 0);
   endtask

   task automatic t_random_seq_read();
      logic ack;
      logic [7:0] d;
      int r0, drv0;
      r0 = n_rd;
      bus_start();
      send_byte(HDR_W, ack);
      send_byte(8'h01, ack);
      send_byte(8'h23, ack);
      bus_start();
      send_byte(HDR_R, ack);  chk("R10 read header after restart", int'(ack), 1);
      recv_byte(d, 1'b1);     chk("R10 first byte from loaded addr", int'(d), int'(mem_val(12'h123)));
      recv_byte(d, 1'b1);     chk("R8 second byte", int'(d), int'(mem_val(12'h124)));
      recv_byte(d, 1'b0);     chk("R8 third byte", int'(d), int'(mem_val(12'h125)));
      chk("R8 read requests", n_rd - r0, 3);
      drv0 = n_drive;
      recv_byte(d, 1'b0);     chk("R9 released after nack", int'(d), 'hFF);
      chk("R9 no request after nack", n_rd - r0, 3);
      chk("R9 no drive after nack", n_drive - drv0, 0);
      bus_stop();
   endtask

   task automatic t_current_read();
      logic ack;
      logic [7:0] d;
      bus_start();
      send_byte(HDR_R, ack);  chk("R2 read header ack", int'(ack), 1);
      recv_byte(d, 1'b0);     chk("R8 current address byte", int'(d), int'(mem_val(12'h126)));
      bus_stop();
   endtask

   task automatic t_abort();
      logic ack;
      logic [7:0] d;
      int c0, w0;
      c0 = n_commit;
      w0 = n_wr;
      bus_start();
      send_byte(HDR_W, ack);
      send_byte(8'h02, ack);
      send_byte(8'h00, ack);
      send_byte(8'h77, ack);
      chk("R11 data before abort", n_wr - w0, 1);
      send_bits(8'h33, 4);
      bus_start();
      send_byte(HDR_R, ack);  chk("R11 header after mid-byte start", int'(ack), 1);
      recv_byte(d, 1'b0);     chk("R11 read after abort", int'(d), int'(mem_val(12'h200)));
      bus_stop();
      pause(4);
      chk("R11 no commit after abort", n_commit - c0, 0);
      chk("R11 no extra write", n_wr - w0, 1);
   endtask

   initial begin
      pause(5);
      rst_n = 1'b1;
      pause(5);
      t_reset();
      t_page_write();
      t_mismatch();
      t_busy();
      t_set_addr();
      t_random_seq_read();
      t_current_read();
      t_abort();
      chk("R12 drive change with SCL high", n_hi_change, 0);
      chk("R12 overlapping strobes", n_multi, 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule